// File: doc/BRIEF.md
# ADC Regular-Group Conversion Sequencer

This block drives the regular conversion group of a multi-channel analog-to-digital converter. It sits between a configuration port, two external trigger lines, an abstract converter and a software-visible data register. A conversion run starts in one of two ways: a software start strobe, or a selected edge on one chosen trigger line. The sequencer then walks a programmed list of up to eight channel numbers and asks the converter for one result per entry. Each result is trimmed to the configured resolution before it is placed in the data register.

Three sequencing styles are available. In single mode each start converts the whole list once. In continuous mode the list repeats until software asks for a stop. In discontinuous mode each start converts only a short burst of entries and remembers where the burst ended. Two flags report to software. The conversion-complete flag marks results that were accepted. The overrun flag marks results that arrived while the previous one was still unread, and the overrun policy decides which value the data register keeps. While a run is in progress the control word and the channel list are frozen against writes.

Top module: `adc_regseq`

## Requirements
- R1: With trigger mode 0 (bits [1:0] of the control word at address 0), only a `sw_start` pulse launches a run, and edges on `trig_in` launch nothing.
- R2: Trigger mode 1 launches a run on a rising edge of the selected line, mode 2 on a falling edge, and mode 3 on either edge. In modes 1 to 3 a `sw_start` pulse has no effect.
- R3: Bit 2 of the control word selects the trigger line: 0 selects `trig_in[0]` and 1 selects `trig_in[1]`. Edges on the other line have no effect.
- R4: In single mode (bits 3 and 4 both clear) a run converts list entries 0 to L in order, where L is control bits [13:11]. The list is written at addresses 8+i with the channel number in data bits [4:0]. `busy` then falls.
- R5: In continuous mode (bit 3 set, bit 4 clear) the list repeats and wraps to entry 0 with no new start. After a `sw_stop` pulse the conversion in progress completes, then the run ends and no further requests follow.
- R6: In discontinuous mode (bit 4 set) each start converts the next B+1 entries, where B is control bits [7:5]. A burst also ends at the end of the list. The next burst resumes at the remembered position, wrapping to entry 0 after entry L.
- R7: Control bits [9:8] select the resolution: 0 keeps all 14 bits, 1 keeps 12, 2 keeps 10 and 3 keeps 8. The kept bits are the upper ones of the converter result, right-aligned in `dr_data` with zeros above.
- R8: A result that completes while the previous one is unread (no `dr_rd` since it was accepted) is an overrun and sets `ovr_flag`. With control bit 10 clear, `dr_data` keeps the old value. With bit 10 set, `dr_data` takes the new result.
- R9: An accepted result sets `eoc_flag`. Writing to address 1 with data bit 0 set clears `eoc_flag`, and data bit 1 clears `ovr_flag`. Each flag is cleared independently of the other.
- R10: Writes to the control word or the channel list while `busy` is high are ignored.
- R11: Trigger edges that arrive while a run is in progress launch nothing, either during the run or after it.
- R12: After reset, `busy`, `conv_req`, `eoc_flag` and `ovr_flag` are low and `dr_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | 0 control word, 1 flag clear, 8 to 15 channel list entries |
| cfg_wdata | input | 14 | Write data |
| sw_start | input | 1 | Software start pulse (trigger mode 0 only) |
| sw_stop | input | 1 | Request to end the run after the conversion in progress |
| trig_in | input | 2 | External trigger lines |
| conv_req | output | 1 | High while a conversion of `conv_chan` is wanted |
| conv_chan | output | 5 | Channel number for the current conversion |
| conv_done | input | 1 | One-cycle pulse: the converter finished and `conv_data` is valid |
| conv_data | input | 14 | Full-width converter result |
| dr_rd | input | 1 | Software read strobe for the data register |
| dr_data | output | 14 | Data register, right-aligned at the chosen resolution |
| eoc_flag | output | 1 | Conversion-complete flag |
| ovr_flag | output | 1 | Overrun flag |
| busy | output | 1 | A regular run is in progress |

## Verification
The assertions assume that the converter raises `conv_done` only while `conv_req` is high, for exactly one cycle per request, and holds `conv_data` valid in that cycle. They also assume that software never sets continuous and discontinuous mode together; if it does, discontinuous mode wins. The converter model in the bench answers each request three cycles after it sees it and then waits for the next request. Every control word the bench writes sets at most one of the two mode bits. All trigger lines are low whenever the control word changes, so switching the line selection never creates a false edge.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int unsigned LIST_N  = 8;
  localparam int unsigned CHW     = 5;
  localparam int unsigned DW      = 14;
  localparam int unsigned PW      = $clog2(LIST_N);
  localparam int unsigned LINES   = 2;
  localparam int unsigned LW      = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int unsigned BURST_W = 3;
  localparam int unsigned AW      = 4;

  typedef enum logic [1:0] {
    TRG_OFF  = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_BOTH = 2'd3
  } trg_mode_e;

  // control word, MSB first
  typedef struct packed {
    logic [PW-1:0]      len_m1;
    logic               ovr_new;
    logic [1:0]         res;
    logic [BURST_W-1:0] burst_m1;
    logic               disc;
    logic               cont;
    logic [LW-1:0]      line;
    trg_mode_e          trig_mode;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;
endpackage

// File: rtl/adcseq_cfg.sv
module adcseq_cfg
  import adcseq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busy,
  input  logic                        cfg_wr,
  input  logic [AW-1:0]               cfg_addr,
  input  logic [CTL_W-1:0]            cfg_wdata,
  output ctl_t                        ctl_o,
  output logic [LIST_N-1:0][CHW-1:0]  list_o,
  output logic                        clr_eoc,
  output logic                        clr_ovr
);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_CLR = AW'(1);

  ctl_t ctl_q, ctl_d;
  logic wr_open;

  assign wr_open = cfg_wr && !busy;
  assign clr_eoc = cfg_wr && (cfg_addr == A_CLR) && cfg_wdata[0];
  assign clr_ovr = cfg_wr && (cfg_addr == A_CLR) && cfg_wdata[1];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_open && (cfg_addr == A_CTL)) ctl_d = ctl_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  for (genvar i = 0; i < LIST_N; i++) begin : g_ent
    logic [CHW-1:0] ent_q, ent_d;
    logic           ent_en;
    assign ent_en = wr_open && cfg_addr[AW-1] && (cfg_addr[PW-1:0] == PW'(i));
    always_comb begin
      ent_d = ent_q;
      if (ent_en) ent_d = cfg_wdata[CHW-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end
    assign list_o[i] = ent_q;
  end

  // R10: control word frozen while a run is active
  assert_cfg_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_q));
  assert_list_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(list_o));
endmodule

// File: rtl/adcseq_trig.sv
module adcseq_trig
  import adcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] trig_in,
  input  logic [LW-1:0]    line,
  input  trg_mode_e        mode,
  output logic             fire
);
  logic sel, sel_q;
  logic rise, fall;

  assign sel  = trig_in[line];
  assign rise = sel && !sel_q;
  assign fall = !sel && sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel;
  end

  always_comb begin
    unique case (mode)
      TRG_RISE: fire = rise;
      TRG_FALL: fire = fall;
      TRG_BOTH: fire = rise || fall;
      default:  fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctl_t                        ctl,
  input  logic [LIST_N-1:0][CHW-1:0]  list_i,
  input  logic                        sw_start,
  input  logic                        sw_stop,
  input  logic                        hw_fire,
  input  logic                        conv_done,
  output logic                        busy,
  output logic                        conv_req,
  output logic [CHW-1:0]              conv_chan
);
  st_e                st_q, st_d;
  logic [PW-1:0]      pos_q, pos_d;
  logic [BURST_W-1:0] burst_q, burst_d;
  logic               stop_q, stop_d;
  logic               launch, last, burst_end;

  assign launch    = (st_q == ST_IDLE) &&
                     ((ctl.trig_mode == TRG_OFF) ? sw_start : hw_fire);
  assign last      = (pos_q == ctl.len_m1);
  assign burst_end = (burst_q == ctl.burst_m1);

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    burst_d = burst_q;
    stop_d  = stop_q;
    unique case (st_q)
      ST_IDLE: begin
        stop_d = 1'b0;
        if (launch) begin
          st_d    = ST_RUN;
          burst_d = '0;
          if (!ctl.disc) pos_d = '0;
        end
      end
      default: begin
        if (sw_stop) stop_d = 1'b1;
        if (conv_done) begin
          pos_d   = last ? '0 : pos_q + PW'(1);
          burst_d = burst_q + BURST_W'(1);
          if (sw_stop || stop_q)       st_d = ST_IDLE;
          else if (ctl.disc) begin
            if (last || burst_end)     st_d = ST_IDLE;
          end
          else if (!ctl.cont && last)  st_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pos_q   <= '0;
      burst_q <= '0;
      stop_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pos_q   <= pos_d;
      burst_q <= burst_d;
      stop_q  <= stop_d;
    end
  end

  assign busy      = (st_q == ST_RUN);
  assign conv_req  = (st_q == ST_RUN);
  assign conv_chan = list_i[pos_q];

  // R4: the requested channel holds until the converter answers
  assert_chan_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> $stable(conv_chan));
  // R6: a burst never runs past its programmed length
  assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl.disc) |-> (burst_q <= ctl.burst_m1));
  // R5: a pending stop ends the run at the next result
  assert_stop_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_q && conv_done) |=> !busy);
endmodule

// File: rtl/adcseq_dreg.sv
module adcseq_dreg
  import adcseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  input  logic [1:0]    res,
  input  logic          ovr_new,
  input  logic          dr_rd,
  input  logic          clr_eoc,
  input  logic          clr_ovr,
  output logic [DW-1:0] dr_data,
  output logic          eoc_flag,
  output logic          ovr_flag
);
  logic [DW-1:0] dr_q, dr_d, trimmed;
  logic          unread_q, unread_d;
  logic          eoc_q, eoc_d, ovr_q, ovr_d;
  logic          over, take;

  assign trimmed = conv_data >> {res, 1'b0};
  assign over    = conv_done && unread_q && !dr_rd;
  assign take    = conv_done && (!over || ovr_new);

  always_comb begin
    dr_d     = take ? trimmed : dr_q;
    unread_d = take ? 1'b1 : (dr_rd ? 1'b0 : unread_q);
    eoc_d    = take || (eoc_q && !clr_eoc);
    ovr_d    = over || (ovr_q && !clr_ovr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q     <= '0;
      unread_q <= 1'b0;
      eoc_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      dr_q     <= dr_d;
      unread_q <= unread_d;
      eoc_q    <= eoc_d;
      ovr_q    <= ovr_d;
    end
  end

  assign dr_data  = dr_q;
  assign eoc_flag = eoc_q;
  assign ovr_flag = ovr_q;

  // R8: keep-old policy leaves the register untouched on overrun
  assert_ovr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && unread_q && !dr_rd && !ovr_new) |=> $stable(dr_data));
  assert_ovr_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && unread_q && !dr_rd) |=> ovr_flag);
  // R9: an accepted result raises the completion flag
  assert_eoc_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !unread_q) |=> eoc_flag);
endmodule

// File: rtl/adc_regseq.sv
module adc_regseq
  import adcseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [CTL_W-1:0]     cfg_wdata,
  input  logic                 sw_start,
  input  logic                 sw_stop,
  input  logic [LINES-1:0]     trig_in,
  output logic                 conv_req,
  output logic [CHW-1:0]       conv_chan,
  input  logic                 conv_done,
  input  logic [DW-1:0]        conv_data,
  input  logic                 dr_rd,
  output logic [DW-1:0]        dr_data,
  output logic                 eoc_flag,
  output logic                 ovr_flag,
  output logic                 busy
);
  ctl_t                       ctl;
  logic [LIST_N-1:0][CHW-1:0] list;
  logic                       clr_eoc, clr_ovr, hw_fire;

  adcseq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ctl_o(ctl), .list_o(list), .clr_eoc(clr_eoc), .clr_ovr(clr_ovr)
  );

  adcseq_trig u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .line(ctl.line), .mode(ctl.trig_mode), .fire(hw_fire)
  );

  adcseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .list_i(list),
    .sw_start(sw_start), .sw_stop(sw_stop), .hw_fire(hw_fire),
    .conv_done(conv_done), .busy(busy), .conv_req(conv_req),
    .conv_chan(conv_chan)
  );

  adcseq_dreg u_dreg (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .res(ctl.res), .ovr_new(ctl.ovr_new), .dr_rd(dr_rd),
    .clr_eoc(clr_eoc), .clr_ovr(clr_ovr),
    .dr_data(dr_data), .eoc_flag(eoc_flag), .ovr_flag(ovr_flag)
  );
endmodule

// File: tb/tb_adc_regseq.sv
module tb_adc_regseq;
  import adcseq_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [AW-1:0]    cfg_addr = '0;
  logic [CTL_W-1:0] cfg_wdata = '0;
  logic             sw_start = 1'b0, sw_stop = 1'b0;
  logic [LINES-1:0] trig_in = '0;
  logic             conv_req, conv_done = 1'b0;
  logic [CHW-1:0]   conv_chan;
  logic [DW-1:0]    conv_data = '0;
  logic             dr_rd = 1'b0;
  logic [DW-1:0]    dr_data;
  logic             eoc_flag, ovr_flag, busy;

  int errors = 0, checks = 0;
  int logc = 0;
  logic [CHW-1:0] logv [64];
  int conv_base = 0;
  int lat_cnt = 0;

  always #2 clk = ~clk;

  adc_regseq dut (.*);

  // converter model: answers each request three cycles after seeing it
  always @(posedge clk) begin
    if (conv_done) begin
      conv_done <= 1'b0;
      lat_cnt   <= 0;
    end else if (conv_req) begin
      if (lat_cnt == 2) begin
        conv_done <= 1'b1;
        conv_data <= DW'(conv_base + 16 * int'(conv_chan));
        if (logc < 64) logv[logc] <= conv_chan;
        logc <= logc + 1;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CTL_W-1:0] mk(input int len_m1, input int ovrn,
      input int res, input int bm1, input int disc, input int cont,
      input int line, input int mode);
    return {3'(len_m1), 1'(ovrn), 2'(res), 3'(bm1), 1'(disc), 1'(cont),
            1'(line), 2'(mode)};
  endfunction

  task automatic wr(input int a, input logic [CTL_W-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic read_dr();
    @(negedge clk); dr_rd = 1'b1;
    @(negedge clk); dr_rd = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!busy && n < 20) begin @(negedge clk); n++; end
    n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic trig_try(input int ln, input logic v, input int exp, input string tag);
    int old;
    old = logc;
    @(negedge clk); trig_in[ln] = v;
    repeat (14) @(negedge clk);
    chk((logc - old) == exp, tag, logc - old, exp);
  endtask

  // resolution table: {res, raw, expected}
  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 14'h3ABC, 14'h3ABC},
    {2'd1, 14'h3ABC, 14'h0EAF},
    {2'd2, 14'h3ABC, 14'h03AB},
    {2'd3, 14'h3ABC, 14'h00EA},
    {2'd3, 14'h3FFF, 14'h00FF},
    {2'd1, 14'h0003, 14'h0000}
  };

  initial begin
    int old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !conv_req, "R12 busy/req after reset", {busy, conv_req}, 0);
    chk(!eoc_flag && !ovr_flag, "R12 flags after reset", {eoc_flag, ovr_flag}, 0);
    chk(dr_data == '0, "R12 data after reset", dr_data, 0);

    // R7 resolution table
    wr(8, 0);
    for (int i = 0; i < NV; i++) begin
      wr(0, mk(0, 0, int'(VEC[i][29:28]), 0, 0, 0, 0, 0));
      conv_base = int'(VEC[i][27:14]);
      pulse_start();
      wait_idle();
      chk(dr_data == VEC[i][13:0], "R7 resolution trim", dr_data, VEC[i][13:0]);
      if (i == 0) chk(eoc_flag, "R9 eoc set on accept", eoc_flag, 1);
      read_dr();
      wr(1, 3);
    end
    chk(!eoc_flag, "R9 eoc cleared by write-one", eoc_flag, 0);

    // R4 single sequence, R10 lock
    conv_base = 0;
    wr(8, 5); wr(9, 9); wr(10, 2); wr(11, 17);
    wr(0, mk(3, 0, 0, 0, 0, 0, 0, 0));
    logc = 0;
    pulse_start();
    wr(0, mk(0, 0, 0, 0, 0, 0, 0, 0));
    wr(8, 30);
    wait_idle();
    chk(logc == 4, "R4 single run length", logc, 4);
    chk(logv[0] == 5 && logv[1] == 9 && logv[2] == 2 && logv[3] == 17,
        "R4 single run order", logv[3], 17);
    chk(!busy, "R4 busy falls after sequence", busy, 0);
    logc = 0;
    pulse_start();
    wait_idle();
    chk(logc == 4, "R10 locked length write ignored", logc, 4);
    chk(logv[0] == 5, "R10 locked list write ignored", logv[0], 5);
    read_dr(); wr(1, 3);

    // R1 / R2 / R3 trigger modes, list of one entry
    wr(0, mk(0, 0, 0, 0, 0, 0, 0, 0));
    trig_try(0, 1'b1, 0, "R1 mode0 rising ignored");
    trig_try(0, 1'b0, 0, "R1 mode0 falling ignored");
    old = logc; pulse_start(); wait_idle();
    chk((logc - old) == 1, "R1 mode0 software start", logc - old, 1);
    wr(0, mk(0, 0, 0, 0, 0, 0, 1, 1));
    old = logc; pulse_start(); repeat (14) @(negedge clk);
    chk((logc - old) == 0, "R2 sw start ignored in edge mode", logc - old, 0);
    trig_try(0, 1'b1, 0, "R3 unselected line ignored");
    trig_try(1, 1'b1, 1, "R2 rising edge launches");
    trig_try(1, 1'b0, 0, "R2 falling ignored in rising mode");
    trig_try(0, 1'b0, 0, "R3 unselected line fall ignored");
    wr(0, mk(0, 0, 0, 0, 0, 0, 1, 2));
    trig_try(1, 1'b1, 0, "R2 rising ignored in falling mode");
    trig_try(1, 1'b0, 1, "R2 falling edge launches");
    wr(0, mk(0, 0, 0, 0, 0, 0, 0, 3));
    trig_try(0, 1'b1, 1, "R2 both-edge rise");
    trig_try(0, 1'b0, 1, "R2 both-edge fall");
    read_dr(); wr(1, 3);

    // R11 edges during a run
    for (int i = 0; i < 8; i++) wr(8 + i, CTL_W'(i));
    wr(0, mk(7, 0, 0, 0, 0, 0, 0, 1));
    logc = 0;
    @(negedge clk); trig_in[0] = 1'b1;
    repeat (4) @(negedge clk); trig_in[0] = 1'b0;
    repeat (4) @(negedge clk); trig_in[0] = 1'b1;
    repeat (4) @(negedge clk); trig_in[0] = 1'b0;
    wait_idle();
    repeat (14) @(negedge clk);
    chk(logc == 8, "R11 edges while busy ignored", logc, 8);
    chk(logv[7] == 7, "R4 eight-entry order", logv[7], 7);
    read_dr(); wr(1, 3);

    // R6 discontinuous bursts of 3 over a list of 5
    for (int i = 0; i < 5; i++) wr(8 + i, CTL_W'(10 + i));
    wr(0, mk(4, 0, 0, 2, 1, 0, 0, 1));
    logc = 0;
    trig_try(0, 1'b1, 3, "R6 first burst length");
    trig_try(0, 1'b0, 0, "R6 no launch on fall");
    trig_try(0, 1'b1, 2, "R6 burst ends at list end");
    trig_try(0, 1'b0, 0, "R6 no launch on fall");
    trig_try(0, 1'b1, 3, "R6 wrapped burst length");
    chk(logv[0] == 10 && logv[2] == 12, "R6 first burst channels", logv[2], 12);
    chk(logv[3] == 13 && logv[4] == 14, "R6 resumed position", logv[3], 13);
    chk(logv[5] == 10 && logv[7] == 12, "R6 wrap to entry 0", logv[5], 10);
    trig_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    read_dr(); wr(1, 3);

    // R5 continuous with stop
    wr(0, mk(2, 0, 0, 0, 0, 1, 0, 0));
    logc = 0;
    pulse_start();
    while (logc < 7) @(negedge clk);
    sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
    wait_idle();
    chk(logc >= 7 && logc <= 9, "R5 run stops after request", logc, 8);
    begin
      bit ok = 1;
      for (int i = 0; i < 9; i++)
        if (i < logc && logv[i] != CHW'(10 + i % 3)) ok = 0;
      chk(ok, "R5 continuous wrap order", logv[3], 10);
    end
    old = logc;
    repeat (20) @(negedge clk);
    chk(logc == old && !busy, "R5 no requests after stop", logc, old);
    read_dr(); wr(1, 3);

    // R8 overrun, keep-old policy
    wr(8, 1); wr(9, 2);
    conv_base = 14'h100;
    wr(0, mk(1, 0, 0, 0, 0, 0, 0, 0));
    pulse_start(); wait_idle();
    chk(dr_data == 14'h110, "R8 keep-old data", dr_data, 14'h110);
    chk(ovr_flag && eoc_flag, "R8 overrun flag set", {ovr_flag, eoc_flag}, 3);
    read_dr(); wr(1, 3);
    chk(!ovr_flag && !eoc_flag, "R9 both flags cleared", {ovr_flag, eoc_flag}, 0);
    // R8 overrun, take-new policy
    wr(0, mk(1, 1, 0, 0, 0, 0, 0, 0));
    pulse_start(); wait_idle();
    chk(dr_data == 14'h120, "R8 take-new data", dr_data, 14'h120);
    wr(1, 2);
    chk(!ovr_flag && eoc_flag, "R9 ovr cleared alone", {ovr_flag, eoc_flag}, 1);
    wr(1, 1);
    chk(!eoc_flag, "R9 eoc cleared alone", eoc_flag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule